// File: doc/BRIEF.md
# Inter-processor mailbox with interrupts

This block lets several processors on one chip pass 32-bit messages to each other through a bank of small hardware queues. A sender writes a word to a queue's message register. A receiver reads the same register to take the oldest word off the queue. Two read-only status registers per queue report whether the queue is full and how many words it holds.

Every processor (a "user") has its own interrupt line, interrupt status register and interrupt enable mask. Each queue raises two events: a new-message event and a no-longer-full event. Both events land in every user's status register. Each user chooses, through its own mask, which events drive its line.

A build-time parameter picks one of two enable-register arrangements. In the first, a single read/write mask is rewritten in full. In the second, separate write-one-to-set and write-one-to-clear addresses are used. The register port is a plain single-cycle bus: read data is valid in the same cycle as the read strobe, and a pop takes effect at the closing clock edge.

Top module: `mbox_top`

## Requirements
- R1: Offset 0x000 returns the build-time revision constant; writes to it change nothing.
- R2: For queue m, the message register is at 0x040+4m, the full flag at 0x080+4m (reads 1 only when the queue holds DEPTH words, else 0) and the word count at 0x0C0+4m.
- R3: Each queue holds up to DEPTH 32-bit words in arrival order. A read of the message register returns the oldest word and removes it.
- R4: A write to a full queue is dropped and leaves the count and contents unchanged. A read of an empty queue returns 0 and leaves the queue unchanged.
- R5: A push and a pop of the same queue in one cycle leave the count unchanged; the read returns the old head.
- R6: Status bit 2m (new message, queue m) is set in every user's status on each accepted push. It cannot be cleared while queue m is non-empty.
- R7: Status bit 2m+1 (not full, queue m) is set in every user's status when a pop takes queue m from full to not full.
- R8: Writing 1 to a status bit clears it, unless its event fires in the same cycle. Writing 0 leaves the bit unchanged.
- R9: A user's interrupt output is high exactly when its status AND its enable mask is nonzero.
- R10: With the rewrite arrangement, user u has status at 0x100+8u and a read/write enable mask at 0x104+8u; a write replaces the mask.
- R11: With the set/clear arrangement, user u has status at 0x104+0x10u, set-enable at 0x108+0x10u and clear-enable at 0x10C+0x10u. Written 1 bits set or clear mask bits, and both enable addresses read back the mask.
- R12: After reset, all queues are empty, all status and enable bits are 0 and all interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a message read pops at the clock edge |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd, 0 when bus_rd is low |
| irq_o | output | NUM_USERS | One interrupt line per user |

## Verification
The bench builds two copies with 2 users, 3 queues and a depth of 4: one copy per enable arrangement. At that size every queue can be filled past capacity and drained past empty in a few dozen accesses. Every status bit of every user, both enable arrangements and all address decodes are then reached. The bench computes expected message words, counts and status masks arithmetically from queue index, user index and fill level.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int MBOX_DW = 32;
  localparam int REV_OFS = 'h000;

  typedef enum logic {
    LAYOUT_RMW    = 1'b0,
    LAYOUT_SETCLR = 1'b1
  } irq_layout_e;

  function automatic int msg_ofs(input int m);
    return 'h040 + 4 * m;
  endfunction

  function automatic int full_ofs(input int m);
    return 'h080 + 4 * m;
  endfunction

  function automatic int cnt_ofs(input int m);
    return 'h0C0 + 4 * m;
  endfunction

  function automatic int stat_ofs(input irq_layout_e l, input int u);
    return (l == LAYOUT_SETCLR) ? ('h104 + 'h10 * u) : ('h100 + 8 * u);
  endfunction

  function automatic int en_ofs(input irq_layout_e l, input int u);
    return (l == LAYOUT_SETCLR) ? ('h108 + 'h10 * u) : ('h104 + 8 * u);
  endfunction

  function automatic int clr_ofs(input int u);
    return 'h10C + 'h10 * u;
  endfunction

endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] head_data,
  output logic          is_full,
  output logic [CW-1:0] count_q,
  output logic [CW-1:0] count_nxt,
  output logic          push_ok,
  output logic          pop_ok
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] wr_ptr_q, wr_ptr_nxt;
  logic [PW-1:0] rd_ptr_q, rd_ptr_nxt;
  logic          ptr_en;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    is_full   = (count_q == CW'(DEPTH));
    push_ok   = push_req && !is_full;
    pop_ok    = pop_req && (count_q != '0);
    ptr_en    = push_ok || pop_ok;
    wr_ptr_nxt = push_ok ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_nxt = pop_ok  ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    unique case ({push_ok, pop_ok})
      2'b10:   count_nxt = count_q + CW'(1);
      2'b01:   count_nxt = count_q - CW'(1);
      default: count_nxt = count_q;
    endcase
    head_data = (count_q == '0) ? '0 : mem_q[rd_ptr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (ptr_en) begin
      wr_ptr_q <= wr_ptr_nxt;
      rd_ptr_q <= rd_ptr_nxt;
      count_q  <= count_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem_q[wr_ptr_q] <= push_data;
    end
  end

endmodule

// File: rtl/mbox_irq_bank.sv
module mbox_irq_bank #(
  parameter int NB = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] ev,
  input  logic          st_ack_wr,
  input  logic          en_load,
  input  logic          en_set,
  input  logic          en_clr,
  input  logic [NB-1:0] wbits,
  output logic [NB-1:0] st_q,
  output logic [NB-1:0] en_q,
  output logic          irq
);

  logic [NB-1:0] st_nxt, en_nxt;
  logic          st_upd, en_upd;

  always_comb begin
    st_upd = st_ack_wr || (|ev);
    st_nxt = (st_q & ~(st_ack_wr ? wbits : '0)) | ev;
    en_upd = en_load || en_set || en_clr;
    if (en_load) begin
      en_nxt = wbits;
    end else begin
      en_nxt = (en_q | (en_set ? wbits : '0)) & ~(en_clr ? wbits : '0);
    end
    irq = |(st_q & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (st_upd) begin
      st_q <= st_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_upd) begin
      en_q <= en_nxt;
    end
  end

endmodule

// File: rtl/mbox_top.sv
module mbox_top
  import mbox_pkg::*;
#(
  parameter int          NUM_USERS = 4,
  parameter int          NUM_FIFOS = 8,
  parameter int          DEPTH     = 4,
  parameter int          ADDR_W    = 9,
  parameter irq_layout_e LAYOUT    = LAYOUT_SETCLR,
  parameter logic [31:0] REV_ID    = 32'h0000_0200
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [31:0]          bus_rdata,
  output logic [NUM_USERS-1:0] irq_o
);

  localparam int NB    = 2 * NUM_FIFOS;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam bit IS_SC = (LAYOUT == LAYOUT_SETCLR);

  logic [NUM_FIFOS-1:0]              push_req, pop_req, push_ok, pop_ok, fifo_full;
  logic [NUM_FIFOS-1:0][CW-1:0]      fifo_cnt, fifo_cnt_nxt;
  logic [NUM_FIFOS-1:0][MBOX_DW-1:0] fifo_head;
  logic [NB-1:0]                     irq_ev;
  logic [NB-1:0]                     wbits;
  logic [NUM_USERS-1:0][NB-1:0]      st_q, en_q;
  logic [NUM_USERS-1:0]              st_wr, en_load, en_set, en_clr;
  logic [31:0]                       rd_val;

  assign wbits = bus_wdata[NB-1:0];

  for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_fifo
    assign push_req[m] = bus_wr && (bus_addr == ADDR_W'(msg_ofs(m)));
    assign pop_req[m]  = bus_rd && (bus_addr == ADDR_W'(msg_ofs(m)));

    mbox_fifo #(
      .DW    (MBOX_DW),
      .DEPTH (DEPTH)
    ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_req  (push_req[m]),
      .push_data (bus_wdata),
      .pop_req   (pop_req[m]),
      .head_data (fifo_head[m]),
      .is_full   (fifo_full[m]),
      .count_q   (fifo_cnt[m]),
      .count_nxt (fifo_cnt_nxt[m]),
      .push_ok   (push_ok[m]),
      .pop_ok    (pop_ok[m])
    );

    // new-message event is a level while the queue stays occupied
    assign irq_ev[2*m]   = (fifo_cnt_nxt[m] != '0);
    assign irq_ev[2*m+1] = fifo_full[m] && pop_ok[m];
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
    assign st_wr[u] = bus_wr && (bus_addr == ADDR_W'(stat_ofs(LAYOUT, u)));

    if (IS_SC) begin : g_sc
      assign en_load[u] = 1'b0;
      assign en_set[u]  = bus_wr && (bus_addr == ADDR_W'(en_ofs(LAYOUT, u)));
      assign en_clr[u]  = bus_wr && (bus_addr == ADDR_W'(clr_ofs(u)));
    end else begin : g_rmw
      assign en_load[u] = bus_wr && (bus_addr == ADDR_W'(en_ofs(LAYOUT, u)));
      assign en_set[u]  = 1'b0;
      assign en_clr[u]  = 1'b0;
    end

    mbox_irq_bank #(
      .NB (NB)
    ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev        (irq_ev),
      .st_ack_wr (st_wr[u]),
      .en_load   (en_load[u]),
      .en_set    (en_set[u]),
      .en_clr    (en_clr[u]),
      .wbits     (wbits),
      .st_q      (st_q[u]),
      .en_q      (en_q[u]),
      .irq       (irq_o[u])
    );
  end

  always_comb begin
    rd_val = '0;
    if (bus_addr == ADDR_W'(REV_OFS)) begin
      rd_val = REV_ID;
    end
    for (int i = 0; i < NUM_FIFOS; i++) begin
      if (bus_addr == ADDR_W'(msg_ofs(i)))  rd_val = fifo_head[i];
      if (bus_addr == ADDR_W'(full_ofs(i))) rd_val = 32'(fifo_full[i]);
      if (bus_addr == ADDR_W'(cnt_ofs(i)))  rd_val = 32'(fifo_cnt[i]);
    end
    for (int i = 0; i < NUM_USERS; i++) begin
      if (bus_addr == ADDR_W'(stat_ofs(LAYOUT, i))) rd_val = 32'(st_q[i]);
      if (bus_addr == ADDR_W'(en_ofs(LAYOUT, i)))   rd_val = 32'(en_q[i]);
      if (IS_SC && (bus_addr == ADDR_W'(clr_ofs(i)))) rd_val = 32'(en_q[i]);
    end
    bus_rdata = bus_rd ? rd_val : '0;
  end

endmodule

// File: rtl/mbox_checker.sv
module mbox_checker #(
  parameter int NUM_USERS = 4,
  parameter int NUM_FIFOS = 8,
  parameter int DEPTH     = 4,
  localparam int NB       = 2 * NUM_FIFOS,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [31:0]                   bus_rdata,
  input logic [NUM_USERS-1:0]          irq_o,
  input logic [NUM_FIFOS-1:0]          push_req,
  input logic [NUM_FIFOS-1:0]          pop_req,
  input logic [NUM_FIFOS-1:0]          push_ok,
  input logic [NUM_FIFOS-1:0]          pop_ok,
  input logic [NUM_FIFOS-1:0]          fifo_full,
  input logic [NUM_FIFOS-1:0][CW-1:0]  fifo_cnt,
  input logic [NUM_USERS-1:0][NB-1:0]  st_q,
  input logic [NUM_USERS-1:0][NB-1:0]  en_q
);

  for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_f
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt[m] <= CW'(DEPTH));

    assert_full_write_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req[m] && fifo_full[m] && !pop_req[m]) |=> $stable(fifo_cnt[m]));

    assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req[m] && (fifo_cnt[m] == '0)) |-> (bus_rdata == '0));

    assert_pushpop_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (push_ok[m] && pop_ok[m]) |=> $stable(fifo_cnt[m]));

    for (genvar u = 0; u < NUM_USERS; u++) begin : g_u
      assert_newmsg_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok[m] |=> st_q[u][2*m]);

      assert_notfull_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full[m] && pop_ok[m]) |=> st_q[u][2*m+1]);
    end
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_q
    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[u] == '0) |-> !irq_o[u]);
  end

endmodule

bind mbox_top mbox_checker #(
  .NUM_USERS (NUM_USERS),
  .NUM_FIFOS (NUM_FIFOS),
  .DEPTH     (DEPTH)
) u_mbox_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .push_req  (push_req),
  .pop_req   (pop_req),
  .push_ok   (push_ok),
  .pop_ok    (pop_ok),
  .fifo_full (fifo_full),
  .fifo_cnt  (fifo_cnt),
  .st_q      (st_q),
  .en_q      (en_q)
);

// File: tb/test_mbox_top.sv
module test_mbox_top;

  localparam int          NU  = 2;
  localparam int          NF  = 3;
  localparam int          D   = 4;
  localparam int          AW  = 9;
  localparam logic [31:0] REV = 32'h0002_0104;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic          wr, rd;
  int            sel;
  logic [31:0]   rdata_a, rdata_b;
  logic [NU-1:0] irq_a, irq_b;
  int            checks, errors;
  bit            done;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  mbox_top #(
    .NUM_USERS (NU), .NUM_FIFOS (NF), .DEPTH (D), .ADDR_W (AW),
    .LAYOUT (mbox_pkg::LAYOUT_SETCLR), .REV_ID (REV)
  ) i_mbox_top (
    .clk (clk), .rst_n (rst_n), .bus_addr (addr), .bus_wdata (wdata),
    .bus_wr (wr && sel == 0), .bus_rd (rd && sel == 0),
    .bus_rdata (rdata_a), .irq_o (irq_a)
  );

  mbox_top #(
    .NUM_USERS (NU), .NUM_FIFOS (NF), .DEPTH (D), .ADDR_W (AW),
    .LAYOUT (mbox_pkg::LAYOUT_RMW), .REV_ID (REV)
  ) i_mbox_top_rmw (
    .clk (clk), .rst_n (rst_n), .bus_addr (addr), .bus_wdata (wdata),
    .bus_wr (wr && sel == 1), .bus_rd (rd && sel == 1),
    .bus_rdata (rdata_b), .irq_o (irq_b)
  );

  function automatic int a_msg(int m);  return 64 + 4 * m;  endfunction
  function automatic int a_full(int m); return 128 + 4 * m; endfunction
  function automatic int a_cnt(int m);  return 192 + 4 * m; endfunction
  function automatic int a_st(int s, int u);
    return (s == 0) ? 260 + 16 * u : 256 + 8 * u;
  endfunction
  function automatic int a_en(int s, int u);
    return (s == 0) ? 264 + 16 * u : 260 + 8 * u;
  endfunction
  function automatic int a_clr(int u); return 268 + 16 * u; endfunction
  function automatic logic [31:0] pat(int s, int m, int k);
    return 32'hC0DE_0000 | (s << 12) | (m << 8) | k;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_w(input int a, input logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_r(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = AW'(a); rd = 1'b1;
    #1 d = (sel == 0) ? rdata_a : rdata_b;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
    logic [31:0] d;
    bus_r(a, d);
    chk(req, d, exp);
  endtask

  task automatic irq_chk(input string req, input logic [NU-1:0] exp);
    @(negedge clk);
    #1 chk(req, 32'((sel == 0) ? irq_a : irq_b), 32'(exp));
  endtask

  task automatic en_set(input int u, input logic [31:0] mask);
    if (sel == 0) bus_w(a_en(0, u), mask);
    else          bus_w(a_en(1, u), mask);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] exp_st;
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; addr = '0; wdata = '0; wr = 1'b0; rd = 1'b0; sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int s = 0; s < 2; s++) begin
      sel = s;
      // R12 reset state
      for (int m = 0; m < NF; m++) begin
        rd_chk("R12 count", a_cnt(m), 0);
        rd_chk("R12 full", a_full(m), 0);
      end
      for (int u = 0; u < NU; u++) begin
        rd_chk("R12 status", a_st(s, u), 0);
        rd_chk("R12 enable", a_en(s, u), 0);
      end
      irq_chk("R12 irq", '0);

      // R1 revision is read-only
      rd_chk("R1 rev", 0, REV);
      bus_w(0, 32'hFFFF_FFFF);
      rd_chk("R1 rev after write", 0, REV);

      // fill every queue, overfill by one
      exp_st = 0;
      for (int m = 0; m < NF; m++) begin
        for (int k = 0; k < D; k++) begin
          bus_w(a_msg(m), pat(s, m, k));
          rd_chk("R2 count", a_cnt(m), k + 1);
          rd_chk("R2 full", a_full(m), (k == D - 1) ? 1 : 0);
        end
        bus_w(a_msg(m), pat(s, m, 9));
        rd_chk("R4 overfill count", a_cnt(m), D);
        exp_st |= 32'(1) << (2 * m);
        for (int u = 0; u < NU; u++) rd_chk("R6 status after push", a_st(s, u), exp_st);
      end

      // user u listens to new-message of queue u
      for (int u = 0; u < NU; u++) begin
        en_set(u, 32'(1) << (2 * u));
        rd_chk(s == 0 ? "R11 enable read" : "R10 enable read", a_en(s, u), 32'(1) << (2 * u));
        if (s == 0) rd_chk("R11 clear-addr read", a_clr(u), 32'(1) << (2 * u));
      end
      irq_chk("R9 irq both", 2'b11);

      // ack while non-empty keeps bit; zero write no effect
      bus_w(a_st(s, 0), 32'h1);
      rd_chk("R6 held while occupied", a_st(s, 0), 32'h15);
      bus_w(a_st(s, 1), 32'h0);
      rd_chk("R8 zero write", a_st(s, 1), 32'h15);

      // drain in order
      for (int m = 0; m < NF; m++) begin
        for (int k = 0; k < D; k++) begin
          rd_chk("R3 order", a_msg(m), pat(s, m, k));
          if (k == 0)
            for (int u = 0; u < NU; u++) begin
              bus_r(a_st(s, u), d);
              chk("R7 not-full bit", (d >> (2 * m + 1)) & 1, 1);
            end
        end
        rd_chk("R4 empty read", a_msg(m), 0);
        rd_chk("R4 empty count", a_cnt(m), 0);
      end
      for (int u = 0; u < NU; u++) rd_chk("R7 final status", a_st(s, u), 32'h3F);

      bus_w(a_st(s, 0), 32'h3F);
      rd_chk("R8 ack clears", a_st(s, 0), 0);
      rd_chk("R8 other user kept", a_st(s, 1), 32'h3F);
      irq_chk("R9 irq user1 only", 2'b10);

      // disable user 1
      if (s == 0) bus_w(a_clr(1), 32'h4);
      else        bus_w(a_en(1, 1), 32'h0);
      rd_chk(s == 0 ? "R11 clear" : "R10 rewrite", a_en(s, 1), 0);
      irq_chk("R9 irq after disable", 2'b00);
      bus_w(a_st(s, 1), 32'h3F);

      // not-full interrupt on user 1
      en_set(1, 32'h2);
      for (int k = 0; k < D; k++) bus_w(a_msg(0), pat(s, 0, k + 4));
      irq_chk("R9 irq only new-message user", 2'b01);
      rd_chk("R3 head", a_msg(0), pat(s, 0, 4));
      irq_chk("R7 not-full irq", 2'b11);

      // simultaneous push and pop
      @(negedge clk);
      addr = AW'(a_msg(0)); wdata = pat(s, 0, 8); wr = 1'b1; rd = 1'b1;
      #1 d = (sel == 0) ? rdata_a : rdata_b;
      @(negedge clk);
      wr = 1'b0; rd = 1'b0;
      chk("R5 old head", d, pat(s, 0, 5));
      rd_chk("R5 count kept", a_cnt(0), 3);
      for (int k = 6; k <= 8; k++) rd_chk("R5 order after", a_msg(0), pat(s, 0, k));
      rd_chk("R4 empty after", a_msg(0), 0);
    end
    summary();
  end

endmodule